// File: doc/BRIEF.md
# Ethernet PHY Bring-Up Sequencer

This block takes an attached Ethernet PHY from power-on to a working link without any software involvement. It drives a plain management request port that carries a valid flag, a read/write flag, the PHY address, a register number and write data. A serial management engine sits behind that port and answers each request with a one-cycle done pulse and, for a read, the data that was read.

A `start` pulse runs a fixed sequence. The block first confirms the PHY identity. It then soft-resets the PHY and waits for the reset to self-clear. Next it advertises every 10/100 ability and restarts autonegotiation. It waits for negotiation to complete and then for the link to come up. Last, it reads the resolved speed and duplex from the vendor status register.

Every wait loop is bounded by a poll budget. If the budget runs out, the block stops in a sticky error state. On success it holds `done` and the resolved mode until the next start.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset, `req_valid`, `busy`, `done`, `error`, `full_duplex` and `speed_100` are all low.
- R2: A start pulse taken while not busy launches the sequence. It reads register 2 at address PHY_ADDR (default 1) and repeats the read until the data equals 0x0007.
- R3: After the identity matches, the block writes 0x8000 to register 0. It then reads register 0 until bit 15 reads back as 0.
- R4: Next the block writes 0x01E1 to register 4 (selector 0x0001 plus ability bits 5 to 8). It then writes 0x1200 to register 0, which sets enable bit 12 and restart bit 9.
- R5: The block then reads register 31 until bit 12 (negotiation complete) is set.
- R6: Each link attempt is two reads of register 1. Only bit 2 of the second read decides whether the link is up, because the first read only clears the latched-low value.
- R7: After link-up, one more read of register 31 sets `speed_100` from bit 3 and `full_duplex` from bit 4, and `done` rises. Both values and `done` hold until the next accepted start.
- R8: Each wait loop allows at most MAX_POLLS failing attempts. When the last one fails, `error` rises and `busy` falls, and no further request is made until the next start.
- R9: Only one request is outstanding at a time. Its fields stay stable while `req_valid` is high until `rsp_done`, and a `rsp_done` pulse with no request outstanding has no effect.
- R10: A start pulse while `busy` is ignored, and the running sequence continues unchanged.
- R11: An accepted start clears `done`, `error`, `speed_100` and `full_duplex` on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse for the bring-up sequence |
| req_valid | output | 1 | Management request pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_phy | output | 5 | PHY address of the request |
| req_reg | output | 5 | Register number of the request |
| req_wdata | output | 16 | Write data |
| rsp_done | input | 1 | One-cycle completion of the pending request |
| rsp_rdata | input | 16 | Read data, valid with rsp_done |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Link up and mode resolved |
| error | output | 1 | A wait loop ran out of attempts |
| full_duplex | output | 1 | Resolved duplex |
| speed_100 | output | 1 | Resolved speed is 100 Mb/s |

## Verification
A wrong state shows up on the request port at once. Because the next request appears in the cycle right after the `rsp_done` that ends the previous one, a skipped step, a wrong register number or a lost poll count produces a mismatched register or write value within one clock. A miscounted poll budget shows up as `error` rising one attempt early or late, or as an extra request. A mode bit taken from the wrong position is visible on `full_duplex` or `speed_100` the cycle after the final status read.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_ID_RD, S_RST_WR, S_RST_RD, S_ADV_WR, S_AN_WR,
    S_ANC_RD, S_LNK_RD1, S_LNK_RD2, S_SPD_RD, S_DONE, S_ERR
  } pbs_state_e;

  localparam logic [4:0] REG_CTRL  = 5'd0;
  localparam logic [4:0] REG_STAT  = 5'd1;
  localparam logic [4:0] REG_ID1   = 5'd2;
  localparam logic [4:0] REG_ADV   = 5'd4;
  localparam logic [4:0] REG_VSTAT = 5'd31;

  localparam int CTRL_RESET_BIT = 15;
  localparam int CTRL_ANEN_BIT  = 12;
  localparam int CTRL_ANRS_BIT  = 9;
  localparam int STAT_LINK_BIT  = 2;
  localparam int VST_ANDONE_BIT = 12;
  localparam int VST_100_BIT    = 3;
  localparam int VST_FDX_BIT    = 4;
  localparam int ADV_ABIL_LSB   = 5;
  localparam int ADV_ABIL_CNT   = 4;

  localparam logic [15:0] ID1_EXPECT   = 16'h0007;
  localparam logic [15:0] ADV_SELECTOR = 16'h0001;

  typedef struct packed {
    logic        valid;
    logic        wr;
    logic [4:0]  regnum;
    logic [15:0] wdata;
  } pbs_req_t;

  function automatic logic [15:0] pbs_bit(int b);
    return 16'(1) << b;
  endfunction

  // Advertisement word: selector plus every 10/100 ability bit.
  function automatic logic [15:0] pbs_adv_word();
    logic [15:0] w;
    w = ADV_SELECTOR;
    for (int i = 0; i < ADV_ABIL_CNT; i++) w = w | pbs_bit(ADV_ABIL_LSB + i);
    return w;
  endfunction

  function automatic pbs_req_t pbs_req_of(pbs_state_e s);
    pbs_req_t r;
    r = '0;
    r.valid = 1'b1;
    case (s)
      S_ID_RD:   r.regnum = REG_ID1;
      S_RST_WR:  begin r.wr = 1'b1; r.regnum = REG_CTRL; r.wdata = pbs_bit(CTRL_RESET_BIT); end
      S_RST_RD:  r.regnum = REG_CTRL;
      S_ADV_WR:  begin r.wr = 1'b1; r.regnum = REG_ADV; r.wdata = pbs_adv_word(); end
      S_AN_WR:   begin
        r.wr = 1'b1; r.regnum = REG_CTRL;
        r.wdata = pbs_bit(CTRL_ANEN_BIT) | pbs_bit(CTRL_ANRS_BIT);
      end
      S_ANC_RD:  r.regnum = REG_VSTAT;
      S_LNK_RD1: r.regnum = REG_STAT;
      S_LNK_RD2: r.regnum = REG_STAT;
      S_SPD_RD:  r.regnum = REG_VSTAT;
      default:   r = '0;
    endcase
    return r;
  endfunction

  function automatic logic pbs_is_poll(pbs_state_e s);
    return (s == S_ID_RD) || (s == S_RST_RD) || (s == S_ANC_RD) || (s == S_LNK_RD2);
  endfunction

  function automatic logic pbs_poll_ok(pbs_state_e s, logic [15:0] d);
    case (s)
      S_ID_RD:   return d == ID1_EXPECT;
      S_RST_RD:  return !d[CTRL_RESET_BIT];
      S_ANC_RD:  return d[VST_ANDONE_BIT];
      S_LNK_RD2: return d[STAT_LINK_BIT];
      default:   return 1'b1;
    endcase
  endfunction

  function automatic pbs_state_e pbs_chain_next(pbs_state_e s);
    case (s)
      S_ID_RD:   return S_RST_WR;
      S_RST_WR:  return S_RST_RD;
      S_RST_RD:  return S_ADV_WR;
      S_ADV_WR:  return S_AN_WR;
      S_AN_WR:   return S_ANC_RD;
      S_ANC_RD:  return S_LNK_RD1;
      S_LNK_RD1: return S_LNK_RD2;
      S_LNK_RD2: return S_SPD_RD;
      S_SPD_RD:  return S_DONE;
      default:   return s;
    endcase
  endfunction

endpackage

// File: rtl/pbs_poll_timer.sv
module pbs_poll_timer #(
  parameter int unsigned MAX_POLLS = 32'h00FF_FFFF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic miss,
  output logic last_try
);
  localparam int unsigned CW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clr)              cnt <= '0;
    else if (miss && !last_try) cnt <= cnt + 1'b1;
  end

  assign last_try = (cnt == CW'(MAX_POLLS - 1));

  // R8: the attempt count never passes the budget
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) < MAX_POLLS);

  // R8: a miss below the limit advances the count by exactly one
  a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && !last_try && !clr) |=> (32'(cnt) == 32'($past(cnt)) + 1));

endmodule

// File: rtl/pbs_mode_latch.sv
module pbs_mode_latch
  import pbs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        capture,
  input  logic [15:0] vstat,
  output logic        full_duplex,
  output logic        speed_100
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_duplex <= 1'b0;
      speed_100   <= 1'b0;
    end else if (clr) begin
      full_duplex <= 1'b0;
      speed_100   <= 1'b0;
    end else if (capture) begin
      full_duplex <= vstat[VST_FDX_BIT];
      speed_100   <= vstat[VST_100_BIT];
    end
  end

  // R7: the captured mode matches the status word it came from
  a_r7_mode_from_status: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !clr) |=> (speed_100 == $past(vstat[VST_100_BIT]) &&
                           full_duplex == $past(vstat[VST_FDX_BIT])));

endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import pbs_pkg::*;
#(
  parameter int unsigned MAX_POLLS = 32'h00FF_FFFF,
  parameter logic [4:0]  PHY_ADDR  = 5'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        req_valid,
  output logic        req_write,
  output logic [4:0]  req_phy,
  output logic [4:0]  req_reg,
  output logic [15:0] req_wdata,
  input  logic        rsp_done,
  input  logic [15:0] rsp_rdata,
  output logic        busy,
  output logic        done,
  output logic        error,
  output logic        full_duplex,
  output logic        speed_100
);

  pbs_state_e state, state_nx;
  pbs_req_t   req;

  // Named internal events
  logic launch, rsp_take, poll_miss, last_try, tmo, tmr_clr, mode_cap;

  assign req      = pbs_req_of(state);
  assign busy     = req.valid;
  assign launch   = start && !busy;
  assign rsp_take = req.valid && rsp_done;
  assign poll_miss = rsp_take && pbs_is_poll(state) && !pbs_poll_ok(state, rsp_rdata);
  assign tmo      = poll_miss && last_try;
  assign tmr_clr  = launch || (rsp_take && !poll_miss && state != S_LNK_RD1);
  assign mode_cap = rsp_take && state == S_SPD_RD;

  always_comb begin
    state_nx = state;
    if (launch)              state_nx = S_ID_RD;
    else if (tmo)            state_nx = S_ERR;
    else if (poll_miss)      state_nx = (state == S_LNK_RD2) ? S_LNK_RD1 : state;
    else if (rsp_take)       state_nx = pbs_chain_next(state);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= state_nx;
  end

  pbs_poll_timer #(.MAX_POLLS(MAX_POLLS)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .miss(poll_miss), .last_try(last_try)
  );

  pbs_mode_latch u_mode (
    .clk(clk), .rst_n(rst_n), .clr(launch), .capture(mode_cap),
    .vstat(rsp_rdata), .full_duplex(full_duplex), .speed_100(speed_100)
  );

  assign req_valid = req.valid;
  assign req_write = req.wr;
  assign req_reg   = req.regnum;
  assign req_wdata = req.wdata;
  assign req_phy   = PHY_ADDR;
  assign done      = (state == S_DONE);
  assign error     = (state == S_ERR);

  // R9: a pending request holds its fields until answered
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rsp_done) |=> (req_valid && $stable(req_reg) &&
                                  $stable(req_write) && $stable(req_wdata)));

  // R8: an exhausted loop lands in error with the request port quiet
  a_r8_timeout_err: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> (error && !req_valid));

  // R8: error never coexists with a request or with done
  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (!req_valid && !done));

  // R10: start while busy leaves the pending request untouched
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !rsp_done) |=> (req_valid && $stable(req_reg) && $stable(req_wdata)));

  // R11: an accepted start clears every result output
  a_r11_launch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (!done && !error && !full_duplex && !speed_100 && busy));

  // R7: done rises only out of the final status read
  a_r7_done_after_status: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(mode_cap));

endmodule

// File: tb/phy_bringup_seq_tb.sv
`timescale 1ns/1ps
module phy_bringup_seq_tb;
  localparam int MAXP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic rsp_done = 1'b0;
  logic [15:0] rsp_rdata = 16'h0;
  logic req_valid, req_write, busy, done, error, full_duplex, speed_100;
  logic [4:0] req_phy, req_reg;
  logic [15:0] req_wdata;

  always #2.5 clk = ~clk;

  phy_bringup_seq #(.MAX_POLLS(MAXP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .req_valid(req_valid), .req_write(req_write), .req_phy(req_phy),
    .req_reg(req_reg), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .busy(busy), .done(done), .error(error),
    .full_duplex(full_duplex), .speed_100(speed_100)
  );

  int checks = 0, errors = 0, cyc = 0;

  // Behavioural model: phase 0 idle, 1..9 request steps, 10 done, 11 error
  int m_phase = 0, m_polls = 0, lat = 0, txn = 0;
  bit m_fd = 0, m_s100 = 0;
  bit start_req = 0, stray_req = 0;

  // PHY script
  int id_bad = 0, rst_busy = 0, anc_wait = 0, lnk_wait = 0;
  bit lnk_first_hi = 0;
  logic [15:0] spd_val = 16'h0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(int ph);
    case (ph)
      1: return "R2";
      2, 3: return "R3";
      4, 5: return "R4";
      6: return "R5";
      7, 8: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [15:0] phy_data(int ph, int pl);
    case (ph)
      1: return (pl < id_bad) ? 16'h0017 : 16'h0007;
      3: return (pl < rst_busy) ? 16'h9000 : 16'h1000;
      6: return (pl < anc_wait) ? 16'h0040 : 16'h1040;
      7: return lnk_first_hi ? 16'h780D : 16'h7809;
      8: return (pl < lnk_wait) ? 16'h7809 : 16'h780D;
      9: return spd_val | 16'h1000;
      default: return 16'h0;
    endcase
  endfunction

  task automatic model_step(logic [15:0] d);
    bit fail;
    fail = 0;
    case (m_phase)
      1: if (d == 16'h0007) m_phase = 2; else fail = 1;
      2: begin m_phase = 3; m_polls = 0; end
      3: if (!d[15]) m_phase = 4; else fail = 1;
      4: m_phase = 5;
      5: begin m_phase = 6; m_polls = 0; end
      6: if (d[12]) begin m_phase = 7; m_polls = 0; end else fail = 1;
      7: m_phase = 8;
      8: if (d[2]) m_phase = 9; else fail = 1;
      9: begin m_phase = 10; m_s100 = d[3]; m_fd = d[4]; end
      default: ;
    endcase
    if (fail) begin
      if (m_polls == MAXP - 1) m_phase = 11;
      else begin
        m_polls++;
        if (m_phase == 8) m_phase = 7;
      end
    end
  endtask

  always @(negedge clk) begin
    bit was_busy;
    bit ev;
    logic [4:0] er;
    logic [15:0] ew;
    logic [15:0] d;
    if (rst_n) begin
      was_busy = (m_phase >= 1 && m_phase <= 9);
      // every-cycle comparison against the model
      ev = was_busy;
      er = 5'd0; ew = 16'h0;
      case (m_phase)
        1: er = 5'd2;
        2: begin er = 5'd0; ew = 16'h8000; end
        3: er = 5'd0;
        4: begin er = 5'd4; ew = 16'h01E1; end
        5: begin er = 5'd0; ew = 16'h1200; end
        6, 9: er = 5'd31;
        7, 8: er = 5'd1;
        default: ;
      endcase
      chk(req_valid == ev, tag_of(m_phase), "req_valid (R9)", req_valid, ev);
      if (ev && req_valid) begin
        chk(req_reg == er, tag_of(m_phase), "req_reg", req_reg, er);
        chk(req_write == (m_phase == 2 || m_phase == 4 || m_phase == 5),
            tag_of(m_phase), "req_write", req_write, (m_phase == 2 || m_phase == 4 || m_phase == 5));
        chk(req_wdata == ew, tag_of(m_phase), "req_wdata", req_wdata, ew);
        chk(req_phy == 5'd1, "R2", "req_phy", req_phy, 1);
      end
      chk(busy == was_busy, "R10", "busy", busy, was_busy);
      chk(done == (m_phase == 10), "R7", "done", done, m_phase == 10);
      chk(error == (m_phase == 11), "R8", "error", error, m_phase == 11);
      chk(full_duplex == m_fd, "R7", "full_duplex", full_duplex, m_fd);
      chk(speed_100 == m_s100, "R7", "speed_100", speed_100, m_s100);

      // responder
      if (rsp_done) rsp_done = 1'b0;
      else if (req_valid) begin
        if (lat == 2) begin
          lat = 0;
          d = phy_data(m_phase, m_polls);
          rsp_rdata = d;
          rsp_done = 1'b1;
          txn++;
          model_step(d);
        end else lat++;
      end else if (stray_req) begin
        stray_req = 0;
        rsp_rdata = 16'hFFFF;
        rsp_done = 1'b1;
      end

      // start handling
      if (start) start = 1'b0;
      if (start_req) begin
        start_req = 0;
        start = 1'b1;
        if (!was_busy) begin
          m_phase = 1; m_polls = 0; m_fd = 0; m_s100 = 0; txn = 0; lat = 0;
        end
      end
    end
  end

  task automatic summary_and_end();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary_and_end();
    end
  end

  task automatic launch();
    start_req = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_end();
    do @(negedge clk); while (!(m_phase == 10 || m_phase == 11));
    repeat (3) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(!req_valid && !busy, "R1", "req_valid|busy after reset", {req_valid, busy}, 0);
    chk(!done && !error, "R1", "done|error after reset", {done, error}, 0);
    chk(!full_duplex && !speed_100, "R1", "mode after reset", {full_duplex, speed_100}, 0);

    // R9 stray completion while idle
    stray_req = 1;
    repeat (4) @(negedge clk); #1;
    chk(!req_valid && !done && !error, "R9", "stray rsp_done effect",
        {req_valid, done, error}, 0);

    // Run A: id retries, reset busy, latched-low link (R6), 100/full
    id_bad = 2; rst_busy = 1; anc_wait = 2; lnk_wait = 1; lnk_first_hi = 1; spd_val = 16'h0018;
    launch();
    wait_end();
    chk(done == 1, "R7", "done run A", done, 1);
    chk(speed_100 == 1 && full_duplex == 1, "R7", "mode run A", {speed_100, full_duplex}, 3);
    chk(txn == 16, "R6", "transactions run A", txn, 16);

    // Run B: start while busy ignored (R10), 10/half
    id_bad = 0; rst_busy = 0; anc_wait = 3; lnk_wait = 0; lnk_first_hi = 0; spd_val = 16'h0004;
    launch();
    chk(full_duplex == 0 && speed_100 == 0 && done == 0, "R11", "cleared on start",
        {done, full_duplex, speed_100}, 0);
    do @(negedge clk); while (m_phase != 6);
    start_req = 1;
    wait_end();
    chk(txn == 12, "R10", "transactions run B", txn, 12);
    chk(done == 1 && speed_100 == 0 && full_duplex == 0, "R7", "mode run B",
        {done, speed_100, full_duplex}, 4);

    // Run C: identity never matches
    id_bad = 100;
    launch();
    wait_end();
    chk(error == 1 && busy == 0, "R8", "error run C", {error, busy}, 2);
    chk(txn == MAXP, "R8", "ID reads before error", txn, MAXP);
    chk(done == 0, "R11", "done cleared run C", done, 0);
    repeat (10) @(negedge clk); #1;
    chk(txn == MAXP && !req_valid, "R8", "quiet after error", txn, MAXP);

    // Run D: error cleared by start, then link timeout
    id_bad = 0; rst_busy = 0; anc_wait = 0; lnk_wait = 100;
    launch(); #1;
    chk(error == 0, "R11", "error cleared by start", error, 0);
    wait_end();
    chk(error == 1, "R8", "link timeout", error, 1);
    chk(txn == 6 + 2 * MAXP, "R8", "transactions run D", txn, 6 + 2 * MAXP);

    // Run E: clean run, 10/full; reset and negotiation first-try
    lnk_wait = 0; spd_val = 16'h0010;
    launch();
    wait_end();
    chk(txn == 9, "R3", "transactions run E", txn, 9);
    chk(done && full_duplex && !speed_100, "R7", "mode run E",
        {done, full_duplex, speed_100}, 6);
    chk(!busy, "R5", "idle after done", busy, 0);
    chk(req_phy == 5'd1, "R4", "default PHY address", req_phy, 1);

    summary_and_end();
  end

endmodule